// File: doc/BRIEF.md
# Interrupt Controller with Vector Generation

This block gathers interrupt requests for a processor core and turns them into a vector number during the acknowledge cycle. Three active-low external request lines sit at fixed priority levels 1, 6 and 7. Each line is synchronized and then qualified either by its level or by a falling edge. Sixteen internal sources raise one-cycle pulses that set bits in a 16-bit pending register. Software clears those bits by writing ones.

When the core acknowledges a level, the block does one of two things. It either forms an 8-bit vector, with three programmable high bits placed above a 5-bit source code, or it raises a flag that tells the bus an external device will drive the vector. A small register port writes the configuration word and reads or clears the pending word.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the configuration word and the pending word read as zero and all three line requests on `irq_req` are low.
- R2: A line in level mode (its edge bit in config bits 5..7 at 0; bit 5 is level 1, bit 6 is level 6) drives its `irq_req` bit high two clock edges after its input goes low. The bit drops two edges after the input returns high.
- R3: A line in edge mode latches a request on the third clock edge after a one-to-zero input transition. The request holds whether the input stays low or goes high, until that level is acknowledged.
- R4: The level-7 line (`irq_req[2]`) behaves as edge-triggered even when config bit 7 is 0. An acknowledge of level 7 clears it while the input stays low.
- R5: When the external-vector bit of the acknowledged line is 1 (config bits 8, 9, 10 for levels 1, 6, 7), `ack_extvec` is 1 and `ack_vector` is 0.
- R6: Once configured, an internal vector is {config bits 15..13, code}. The code is 16 plus the level for a line acknowledge, and the pending-bit index for any other level.
- R7: Until the configuration word has been written once since reset, every internally generated vector reads 8'h0F.
- R8: An `int_req` pulse sets its pending bit. Writing 1 to a pending bit (reg_sel=1) clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R9: With several pending bits, the highest index supplies the source code.
- R10: Acknowledging a level other than 1, 6 or 7 with nothing pending returns 8'h18.
- R11: Config bits 12, 11 and 4..0 always read 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req_n | input | 3 | External requests, active low; [0]=level 1, [1]=level 6, [2]=level 7 |
| int_req | input | 16 | Internal source pulses, one per pending bit |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects config, 1 selects pending |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ack_valid | input | 1 | Acknowledge cycle active |
| ack_level | input | 3 | Level being acknowledged |
| ack_vector | output | 8 | Vector number returned |
| ack_extvec | output | 1 | External device supplies the vector |
| irq_req | output | 3 | Conditioned line requests toward the core |

## Verification
The assertions assume that `ack_valid` is held for a single cycle per acknowledge and that `int_req` pulses do not have to be counted, since repeated sets merge into one pending bit. They also assume that the external inputs are slow relative to the clock. The stimulus drives every input on the falling clock edge and pulses each acknowledge for one cycle. It holds each external level for at least three edges, so that every transition crosses the synchronizer cleanly before it is judged.

// File: rtl/irq_vec_pkg.sv
// Package: shared sizes, constants and level mapping for the interrupt
// controller. Assumes three external lines in a fixed order.
package irq_vec_pkg;
    parameter int unsigned NLINES    = 3;
    parameter int unsigned SRC_W     = 16;
    parameter int unsigned VEC_W     = 8;
    parameter int unsigned CODE_W    = 5;
    parameter int unsigned LVL_W     = 3;
    parameter int unsigned LINE_CODE_BASE = 16;
    localparam logic [VEC_W-1:0] VEC_UNINIT = 8'h0F;
    localparam logic [VEC_W-1:0] VEC_SPUR   = 8'h18;

    // Priority level served by external line i.
    function automatic logic [LVL_W-1:0] line_level(input int i);
        case (i)
            0:       return LVL_W'(1);
            1:       return LVL_W'(6);
            default: return LVL_W'(7);
        endcase
    endfunction
endpackage

// File: rtl/irq_line_cond.sv
// Conditions one active-low external request line: two-flop synchronizer,
// falling-edge detector and an edge latch cleared on acknowledge.
// Assumes the input may be asynchronous; FORCE_EDGE pins the line to edge mode.
module irq_line_cond #(
    parameter bit FORCE_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic edge_mode,
    input  logic ack_clr,
    output logic req
);
    logic s1_q, s2_q, prev_q, flag_q;
    logic fall;

    // Synchronize the input and keep its previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= req_n;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fall = prev_q & ~s2_q;

    // Edge latch: a new falling edge wins over an acknowledge clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (fall)    flag_q <= 1'b1;
        else if (ack_clr) flag_q <= 1'b0;
    end

    assign req = (FORCE_EDGE || edge_mode) ? flag_q : ~s2_q;

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ack_clr) |=> flag_q);
    // R3
    edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> !$past(s2_q));
endmodule

// File: rtl/irq_pend_reg.sv
// Pending register for internal sources: pulses set bits, write-one clears.
// Assumes set has priority over clear in the same cycle.
module irq_pend_reg #(
    parameter int unsigned W = irq_vec_pkg::SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    // Update pending bits with clear first, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
    // R8
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_vec_gen.sv
// Vector former: picks the highest pending internal source, decodes the
// acknowledged level to a line, and builds the vector or the external flag.
// Assumes ack_valid lasts one cycle per acknowledge.
module irq_vec_gen
    import irq_vec_pkg::*;
#(
    parameter int unsigned W = SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    input  logic [W-1:0]      pend,
    input  logic [NLINES-1:0] ext_vsel,
    input  logic [2:0]        vec_hi,
    input  logic              vec_written,
    output logic [VEC_W-1:0]  vector,
    output logic              extvec,
    output logic [NLINES-1:0] line_hit
);
    logic              found;
    logic [CODE_W-1:0] src_idx;
    logic [CODE_W-1:0] line_code;
    logic              any_line;

    // Highest-index pending source wins.
    always_comb begin
        found   = 1'b0;
        src_idx = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (pend[i]) begin
                found   = 1'b1;
                src_idx = CODE_W'(i);
            end
        end
    end

    // Decode the acknowledged level onto each external line.
    for (genvar g = 0; g < NLINES; g++) begin : g_hit
        assign line_hit[g] = ack_valid && (ack_level == line_level(g));
    end

    // Source code of the acknowledged line.
    always_comb begin
        line_code = '0;
        for (int i = 0; i < int'(NLINES); i++)
            if (line_hit[i]) line_code = CODE_W'(LINE_CODE_BASE + int'(line_level(i)));
    end

    assign any_line = |line_hit;

    // Form the returned vector or the external-vector flag.
    always_comb begin
        extvec = 1'b0;
        vector = '0;
        if (ack_valid) begin
            if (|(line_hit & ext_vsel))  extvec = 1'b1;
            else if (!any_line && !found) vector = VEC_SPUR;
            else if (!vec_written)       vector = VEC_UNINIT;
            else                         vector = {vec_hi, any_line ? line_code : src_idx};
        end
    end

    // R5
    extvec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        extvec |-> (vector == '0));
    // R10
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !any_line && pend == '0) |-> (vector == VEC_SPUR));
    // R7
    uninit_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !vec_written && !extvec && (any_line || pend != '0))
            |-> (vector == VEC_UNINIT));
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the interrupt controller: configuration register, three conditioned
// external lines, internal pending register and vector formation.
// Assumes a single-cycle register write strobe and combinational read.
module irq_vector_ctrl
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ext_req_n,
    input  logic [SRC_W-1:0]  int_req,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    output logic [VEC_W-1:0]  ack_vector,
    output logic              ack_extvec,
    output logic [NLINES-1:0] irq_req
);
    localparam int unsigned EDGE_LSB = 5;
    localparam int unsigned XVEC_LSB = 8;
    localparam int unsigned VHI_LSB  = 13;
    localparam logic [15:0] CFG_MASK = 16'hE7E0;

    logic [15:0]       cfg_q;
    logic              written_q;
    logic [SRC_W-1:0]  pend;
    logic [SRC_W-1:0]  clr;
    logic [NLINES-1:0] hit;

    // Hold the configuration word with reserved bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            written_q <= 1'b0;
        end else if (reg_wr && !reg_sel) begin
            cfg_q     <= reg_wdata & CFG_MASK;
            written_q <= 1'b1;
        end
    end

    assign clr       = (reg_wr && reg_sel) ? reg_wdata[SRC_W-1:0] : '0;
    assign reg_rdata = reg_sel ? 16'(pend) : cfg_q;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        irq_line_cond #(.FORCE_EDGE(line_level(g) == LVL_W'(7))) u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_n     (ext_req_n[g]),
            .edge_mode (cfg_q[EDGE_LSB+g]),
            .ack_clr   (hit[g]),
            .req       (irq_req[g])
        );
    end

    irq_pend_reg #(.W(SRC_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (int_req),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_vec_gen #(.W(SRC_W)) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_valid   (ack_valid),
        .ack_level   (ack_level),
        .pend        (pend),
        .ext_vsel    (cfg_q[XVEC_LSB +: NLINES]),
        .vec_hi      (cfg_q[VHI_LSB +: 3]),
        .vec_written (written_q),
        .vector      (ack_vector),
        .extvec      (ack_extvec),
        .line_hit    (hit)
    );

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[12:11] == 2'b00 && reg_rdata[4:0] == 5'b0));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares.
module irq_vector_ctrl_tb;
    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_req_n = 3'b111;
    logic [15:0] int_req = '0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_level = '0;
    logic [7:0]  ack_vector;
    logic        ack_extvec;
    logic [2:0]  irq_req;

    typedef struct {string req; int kind; logic [15:0] exp;} item_t;
    item_t q[$];
    event  sample_ev;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .int_req(int_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
        .ack_vector(ack_vector), .ack_extvec(ack_extvec), .irq_req(irq_req)
    );

    // Monitor: pop expected items and compare against the observed ports.
    initial forever begin
        @(sample_ev);
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {8'h00, ack_vector};
                2:       act = {15'h0, ack_extvec};
                default: act = {13'h0, irq_req};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input string r, input int k, input logic [15:0] e);
        q.push_back('{r, k, e});
    endtask

    task automatic fire();
        ->sample_ev;
        #0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_chk(input string r, input logic sel, input logic [15:0] e);
        reg_sel = sel;
        #1;
        push(r, 0, e);
        fire();
    endtask

    task automatic irq_chk(input string r, input logic [2:0] e);
        #1;
        push(r, 3, {13'h0, e});
        fire();
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] m);
        int_req = m;
        tick(1);
        int_req = '0;
    endtask

    task automatic ack(input string r, input logic [2:0] lvl, input logic [7:0] ev, input logic ex);
        ack_valid = 1'b1; ack_level = lvl;
        #1;
        push(r, 1, {8'h00, ev});
        push(r, 2, {15'h0, ex});
        fire();
        tick(1);
        ack_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        read_chk("R1", 1'b0, 16'h0000);
        read_chk("R1", 1'b1, 16'h0000);
        irq_chk("R1", 3'b000);
        // R10 spurious before any source
        ack("R10", 3'd4, 8'h18, 1'b0);
        // R7 fallback vector before config write
        pulse(16'h0008);
        read_chk("R8", 1'b1, 16'h0008);
        ack("R7", 3'd4, 8'h0F, 1'b0);
        ack("R7", 3'd6, 8'h0F, 1'b0);
        // R11 config write with reserved bits set
        wr(1'b0, 16'hB95F);
        read_chk("R11", 1'b0, 16'hA140);
        // R6 internal vector {101, 00011}
        ack("R6", 3'd4, 8'hA3, 1'b0);
        // R9 highest index wins
        pulse(16'h0201);
        read_chk("R8", 1'b1, 16'h0209);
        ack("R9", 3'd4, 8'hA9, 1'b0);
        // R8 write-one clear, zeros untouched
        wr(1'b1, 16'h0200);
        read_chk("R8", 1'b1, 16'h0009);
        // R8 set and clear in the same cycle: set wins
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0001; int_req = 16'h0001;
        tick(1);
        reg_wr = 1'b0; int_req = '0;
        read_chk("R8", 1'b1, 16'h0009);
        wr(1'b1, 16'h0009);
        read_chk("R8", 1'b1, 16'h0000);
        // R10 spurious after configuration
        ack("R10", 3'd4, 8'h18, 1'b0);
        // R2 level line 1
        ext_req_n = 3'b110;
        tick(2);
        irq_chk("R2", 3'b001);
        // R5 external vector for level 1
        ack("R5", 3'd1, 8'h00, 1'b1);
        irq_chk("R2", 3'b001);
        ext_req_n = 3'b111;
        tick(2);
        irq_chk("R2", 3'b000);
        // R3 edge line 6
        ext_req_n = 3'b101;
        tick(3);
        irq_chk("R3", 3'b010);
        ext_req_n = 3'b111;
        tick(3);
        irq_chk("R3", 3'b010);
        ack("R6", 3'd6, 8'hB6, 1'b0);
        irq_chk("R3", 3'b000);
        // R4 level 7 edge despite config bit 7 = 0
        ext_req_n = 3'b011;
        tick(3);
        irq_chk("R4", 3'b100);
        ack("R6", 3'd7, 8'hB7, 1'b0);
        irq_chk("R4", 3'b000);
        tick(2);
        irq_chk("R4", 3'b000);
        ext_req_n = 3'b111;
        tick(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule